// File: doc/BRIEF.md
# Radix-16 FFT Address Generator

This block drives the address bus of one memory port of a pass-based FFT engine. A transform is run as a series of passes over a block of N = 2^L points. Each pass walks every index 0..N-1 exactly once, and the mode chooses how each index maps to an address. The first mode stores the block in digit-reversed order. The second visits the butterfly groups of a radix-2, radix-4 or radix-16 stage. The third reads the block out in plain order. A 4096-point radix-16 transform, for example, is one digit-reversed load, three butterfly passes (pass index 0, 1, 2) and one linear unload. These five passes can be issued back to back.

The caller pulses `start_i` with the mode, radix, log2 size and pass index. The block latches that configuration and then emits one address per clock, qualified by `valid_o`. It raises `last_o` on the final address. Twiddle coefficients and the arithmetic are handled elsewhere.

Top module: `fft_addr_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `addr_o`, `valid_o` and `last_o` are all 0.
- R2: A start that is accepted at a rising edge produces the first address after the following rising edge. This first address is always 0. Then `valid_o` stays high for exactly N consecutive cycles, and the pass delivers exactly N addresses.
- R3: `last_o` is high only together with the N-th address of a pass. If no new pass was accepted, `valid_o` is low in the next cycle.
- R4: A start that arrives while a pass is running and has not reached its final index is ignored. The running pass keeps its latched configuration and its address sequence.
- R5: Mode code 0 (linear) outputs 0, 1, ..., N-1 in order. Mode code 3 behaves the same way.
- R6: Mode code 1 (digit reverse) uses the radix codes 0 = radix-2 (1-bit digits), 1 = radix-4 (2-bit digits), 2 or 3 = radix-16 (4-bit digits). With w bits per digit, m = floor(L/w) and rem = L mod w, digit j of index k (bits k[j*w +: w], for j < m) is placed at address bits [L-1-j*w -: w].
- R7: In digit-reverse mode with rem > 0, the leftover top bits k[L-1 : m*w] fill the lowest address bits [rem-1:0].
- R8: In mode code 2 (butterfly pass p), let left = L - p*w. When left >= w, index k = g*r + j (j < r = 2^w) maps to address (g / s)*s*r + j*s + (g mod s), where s = 2^(left-w). The r members of each group are therefore spaced by the stride N / r^(p+1).
- R9: In butterfly mode with 0 < left < w (the final mixed-radix stage), the groups have 2^left members at stride 1. Each group occupies consecutive addresses.
- R10: Every pass, in every mode, outputs each address 0..N-1 exactly once.
- R11: A start sampled at the edge where the running pass issues its final index is accepted. The new pass's first address follows the previous `last_o` cycle with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new pass |
| mode_i | input | 2 | 0 linear, 1 digit reverse, 2 butterfly, 3 linear |
| radix_i | input | 2 | 0 radix-2, 1 radix-4, 2/3 radix-16 |
| log2n_i | input | $clog2(LOG2_MAX+1) | L, log2 of the block size, 1..LOG2_MAX |
| pass_i | input | $clog2(LOG2_MAX) | Butterfly pass index p |
| addr_o | output | LOG2_MAX | Memory address |
| valid_o | output | 1 | Address qualifier |
| last_o | output | 1 | Final address of the pass |

## Verification
The assertions assume that `log2n_i` lies between 1 and LOG2_MAX whenever a start is accepted. In butterfly mode they also assume that `pass_i` leaves at least one bit to process (p*w < L). Outside these limits the end-of-pass count and the group widths are undefined. The stimulus uses only sizes from 2 to 4096 points. Every butterfly pass index it applies is below ceil(L/w). The one out-of-profile start it issues is a deliberately ignored request in the middle of a pass.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;

  typedef enum logic [1:0] {
    AGU_LINEAR = 2'd0,
    AGU_DIGREV = 2'd1,
    AGU_BFLY   = 2'd2,
    AGU_SPARE  = 2'd3
  } agu_mode_e;

  // log2 of digit width in bits: radix-2 -> 0, radix-4 -> 1, radix-16 -> 2
  function automatic logic [1:0] digit_log2(input logic [1:0] radix);
    case (radix)
      2'd0:    digit_log2 = 2'd0;
      2'd1:    digit_log2 = 2'd1;
      default: digit_log2 = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import fft_agu_pkg::*;
#(
  parameter int AW = 18,
  parameter int LW = 5,
  parameter int PW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       radix_i,
  input  logic [LW-1:0]    log2n_i,
  input  logic [PW-1:0]    pass_i,
  output logic             run_o,
  output logic             at_end_o,
  output logic [AW-1:0]    cnt_o,
  output agu_mode_e        mode_o,
  output logic [1:0]       dl_o,
  output logic [LW-1:0]    log2n_o,
  output logic [LW-1:0]    nd_o,
  output logic [LW-1:0]    rem_o,
  output logic [LW-1:0]    gw_o,
  output logic [LW-1:0]    ep_o
);

  logic          run_q;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] end_mask_q;
  logic [AW-1:0] end_mask_d;
  logic          at_end;
  logic          accept;

  logic [1:0] dl_d;
  int         l_int, w_int, left_int, gw_int, ep_int, nd_int, rem_int;

  // Decode geometry once, at start, so the per-cycle path is shifts and masks only
  always_comb begin
    dl_d     = digit_log2(radix_i);
    l_int    = int'(log2n_i);
    w_int    = 1 << dl_d;
    nd_int   = l_int >> dl_d;
    rem_int  = l_int & (w_int - 1);
    left_int = l_int - (int'(pass_i) << dl_d);
    if (left_int < 1) left_int = 1;
    gw_int   = (left_int < w_int) ? left_int : w_int;
    ep_int   = left_int - gw_int;
  end

  assign end_mask_d = {AW{1'b1}} >> (AW - l_int);
  assign at_end     = run_q && (cnt_q == end_mask_q);
  assign accept     = start_i && (!run_q || at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      end_mask_q <= '0;
      mode_o     <= AGU_LINEAR;
      dl_o       <= '0;
      log2n_o    <= '0;
      nd_o       <= '0;
      rem_o      <= '0;
      gw_o       <= '0;
      ep_o       <= '0;
    end else if (accept) begin
      run_q      <= 1'b1;
      cnt_q      <= '0;
      end_mask_q <= end_mask_d;
      mode_o     <= agu_mode_e'(mode_i);
      dl_o       <= dl_d;
      log2n_o    <= log2n_i;
      nd_o       <= LW'(nd_int);
      rem_o      <= LW'(rem_int);
      gw_o       <= LW'(gw_int);
      ep_o       <= LW'(ep_int);
    end else if (run_q) begin
      if (at_end) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign run_o    = run_q;
  assign at_end_o = at_end;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/agu_addr_map.sv
module agu_addr_map
  import fft_agu_pkg::*;
#(
  parameter int AW = 18,
  parameter int LW = 5
) (
  input  agu_mode_e     mode_i,
  input  logic [AW-1:0] cnt_i,
  input  logic [1:0]    dl_i,
  input  logic [LW-1:0] log2n_i,
  input  logic [LW-1:0] nd_i,
  input  logic [LW-1:0] rem_i,
  input  logic [LW-1:0] gw_i,
  input  logic [LW-1:0] ep_i,
  output logic [AW-1:0] addr_o
);

  localparam int IW = (AW > 1) ? $clog2(AW) : 1;

  logic [AW-1:0] rev;
  logic [IW-1:0] src;
  logic [AW-1:0] grp, mem, g_mask, e_mask, bfly;

  // Digit reversal: each output bit picks one source bit of the index
  always_comb begin
    rev = '0;
    src = '0;
    for (int b = 0; b < AW; b++) begin
      if (b < int'(log2n_i)) begin
        if (b < int'(rem_i))
          src = IW'((int'(nd_i) << dl_i) + b);
        else
          src = IW'(((int'(nd_i) - 1 - ((b - int'(rem_i)) >> dl_i)) << dl_i)
                    + ((b - int'(rem_i)) & ((1 << dl_i) - 1)));
        rev[b] = cnt_i[src];
      end
    end
  end

  // Butterfly: low gw bits of the index are the member, inserted at bit ep
  always_comb begin
    g_mask = ~({AW{1'b1}} << gw_i);
    e_mask = ~({AW{1'b1}} << ep_i);
    mem    = cnt_i & g_mask;
    grp    = cnt_i >> gw_i;
    bfly   = ((grp & ~e_mask) << gw_i) | (mem << ep_i) | (grp & e_mask);
  end

  always_comb begin
    case (mode_i)
      AGU_DIGREV: addr_o = rev;
      AGU_BFLY:   addr_o = bfly;
      default:    addr_o = cnt_i;
    endcase
  end

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          last_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      last_o  <= last_i;
      addr_o  <= valid_i ? addr_i : '0;
    end
  end

endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen
  import fft_agu_pkg::*;
#(
  parameter int LOG2_MAX = 18
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [1:0]                        mode_i,
  input  logic [1:0]                        radix_i,
  input  logic [$clog2(LOG2_MAX+1)-1:0]     log2n_i,
  input  logic [$clog2(LOG2_MAX)-1:0]       pass_i,
  output logic [LOG2_MAX-1:0]               addr_o,
  output logic                              valid_o,
  output logic                              last_o
);

  localparam int AW = LOG2_MAX;
  localparam int LW = $clog2(LOG2_MAX + 1);
  localparam int PW = $clog2(LOG2_MAX);

  logic          run, at_end;
  logic [AW-1:0] cnt, addr_d;
  agu_mode_e     cfg_mode;
  logic [1:0]    cfg_dl;
  logic [LW-1:0] cfg_log2n, cfg_nd, cfg_rem, cfg_gw, cfg_ep;

  agu_ctrl #(.AW(AW), .LW(LW), .PW(PW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .radix_i  (radix_i),
    .log2n_i  (log2n_i),
    .pass_i   (pass_i),
    .run_o    (run),
    .at_end_o (at_end),
    .cnt_o    (cnt),
    .mode_o   (cfg_mode),
    .dl_o     (cfg_dl),
    .log2n_o  (cfg_log2n),
    .nd_o     (cfg_nd),
    .rem_o    (cfg_rem),
    .gw_o     (cfg_gw),
    .ep_o     (cfg_ep)
  );

  agu_addr_map #(.AW(AW), .LW(LW)) u_map (
    .mode_i  (cfg_mode),
    .cnt_i   (cnt),
    .dl_i    (cfg_dl),
    .log2n_i (cfg_log2n),
    .nd_i    (cfg_nd),
    .rem_i   (cfg_rem),
    .gw_i    (cfg_gw),
    .ep_i    (cfg_ep),
    .addr_o  (addr_d)
  );

  agu_out_stage #(.AW(AW)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (run),
    .last_i  (at_end),
    .addr_i  (addr_d),
    .valid_o (valid_o),
    .last_o  (last_o),
    .addr_o  (addr_o)
  );

endmodule

// File: rtl/fft_addr_gen_chk.sv
module fft_addr_gen_chk #(
  parameter int AW = 18,
  parameter int LW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_o,
  input logic          last_o,
  input logic [AW-1:0] addr_o,
  input logic          run_i,
  input logic          at_end_i,
  input logic [1:0]    mode_i,
  input logic [LW-1:0] log2n_i
);

  a_r3_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r3_stop_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !run_i |=> !valid_o);

  a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o |=> valid_o);

  a_r2_first_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (!$past(valid_o) || $past(last_o)) |-> addr_o == '0);

  a_r5_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && mode_i == 2'd0 |=> addr_o == $past(addr_o) + 1'b1);

  a_r4_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !at_end_i |=> $stable(mode_i) && $stable(log2n_i));

endmodule

bind fft_addr_gen fft_addr_gen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_o  (valid_o),
  .last_o   (last_o),
  .addr_o   (addr_o),
  .run_i    (run),
  .at_end_i (at_end),
  .mode_i   (cfg_mode),
  .log2n_i  (cfg_log2n)
);

// File: tb/fft_addr_gen_test.sv
module fft_addr_gen_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  radix_i = '0;
  logic [4:0]  log2n_i = '0;
  logic [4:0]  pass_i = '0;
  logic [17:0] addr_o;
  logic        valid_o;
  logic        last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];
  bit last_q[$];
  logic [4095:0] seen = '0;
  bit in_pass = 1'b0;

  always #2.5ns clk_i = ~clk_i;

  fft_addr_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .radix_i(radix_i), .log2n_i(log2n_i), .pass_i(pass_i),
    .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int model(int mode, int radix, int l, int p, int k);
    int w, r, m, rem, tmp, rev, left, gb, e, gs, s, g, j;
    w = (radix == 0) ? 1 : (radix == 1) ? 2 : 4;
    r = 1 << w;
    if (mode == 1) begin
      m = l / w; rem = l % w; tmp = k; rev = 0;
      for (int d = 0; d < m; d++) begin
        rev = rev * r + tmp % r;
        tmp = tmp / r;
      end
      return rev * (1 << rem) + tmp;
    end else if (mode == 2) begin
      left = l - p * w;
      gb = (left < w) ? left : w;
      e = left - gb; gs = 1 << gb; s = 1 << e;
      g = k / gs; j = k % gs;
      return (g / s) * s * gs + j * s + g % s;
    end
    return k;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: queue expected addresses, then issue the pass
  task automatic run_pass(int mode, int radix, int l, int p, bit glitch, int gap, bit fresh, string req);
    int n = 1 << l;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model(mode, radix, l, p, k));
      last_q.push_back(k == n - 1);
    end
    start_i = 1'b1; mode_i = mode[1:0]; radix_i = radix[1:0];
    log2n_i = l[4:0]; pass_i = p[4:0];
    @(negedge clk_i);
    if (fresh) check(valid_o == 1'b0, {req, "/R2 latency"}, int'(valid_o), 0);
    for (int c = 1; c < n; c++) begin
      if (glitch && c == n / 2) begin
        start_i = 1'b1; mode_i = 2'd1; log2n_i = 5'd3; radix_i = 2'd0;  // R4: must be ignored
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      if (fresh && c == 1) check(valid_o == 1'b1, {req, "/R2 first"}, int'(valid_o), 1);
    end
    start_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  // Monitor: pop and compare on every valid address
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected address", int'(addr_o), -1);
        end else begin
          int ea;
          bit el;
          ea = exp_q.pop_front();
          el = last_q.pop_front();
          check(int'(addr_o) == ea && last_o == el, "R5-R9 address/last",
                int'(addr_o) * 2 + int'(last_o), ea * 2 + int'(el));
          if (addr_o >= 18'd4096 || seen[addr_o[11:0]])
            check(1'b0, "R10 repeated address", int'(addr_o), -1);
          else
            seen[addr_o[11:0]] = 1'b1;
          if (last_o) seen = '0;
        end
        in_pass = !last_o;
      end else begin
        if (last_o) check(1'b0, "R3 last without valid", 1, 0);
        if (in_pass) check(1'b0, "R2 gap inside pass", 0, 1);
        in_pass = 1'b0;
      end
    end
  end

  initial begin
    repeat (1000 * 150) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0 && last_o == 1'b0 && addr_o == '0, "R1 in reset",
          int'(addr_o) + int'(valid_o) + int'(last_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o == 1'b0 && last_o == 1'b0 && addr_o == '0, "R1 after release",
          int'(addr_o) + int'(valid_o) + int'(last_o), 0);

    run_pass(0, 2, 4, 0, 0, 3, 1, "R5 linear");
    run_pass(3, 2, 3, 0, 0, 3, 1, "R5 spare mode");
    run_pass(1, 2, 4, 0, 0, 3, 1, "R6 digrev 16");
    run_pass(1, 2, 8, 0, 0, 3, 1, "R6 digrev 256");
    run_pass(1, 0, 3, 0, 0, 3, 1, "R6 bitrev 8");
    run_pass(1, 2, 5, 0, 0, 3, 1, "R7 digrev 32");
    run_pass(1, 1, 5, 0, 0, 3, 1, "R7 radix4 32");
    run_pass(1, 1, 1, 0, 0, 3, 1, "R7 radix4 2");
    // 4k flow, back to back (R11)
    run_pass(1, 2, 12, 0, 0, 0, 1, "R11 load");
    run_pass(2, 2, 12, 0, 0, 0, 0, "R8 pass0");
    run_pass(2, 2, 12, 1, 0, 0, 0, "R8 pass1");
    run_pass(2, 2, 12, 2, 0, 0, 0, "R8 pass2");
    run_pass(0, 2, 12, 0, 0, 3, 0, "R11 unload");
    run_pass(2, 2, 5, 0, 0, 3, 1, "R8 r16 n32 p0");
    run_pass(2, 2, 5, 1, 0, 3, 1, "R9 r16 n32 p1");
    run_pass(2, 1, 6, 0, 0, 0, 1, "R8 r4 p0");
    run_pass(2, 1, 6, 1, 0, 0, 0, "R8 r4 p1");
    run_pass(2, 1, 6, 2, 0, 3, 0, "R8 r4 p2");
    run_pass(2, 1, 5, 2, 0, 3, 1, "R9 r4 n32 p2");
    run_pass(2, 0, 3, 0, 0, 0, 1, "R8 r2 p0");
    run_pass(2, 0, 3, 1, 0, 0, 0, "R8 r2 p1");
    run_pass(2, 0, 3, 2, 0, 3, 0, "R8 r2 p2");
    run_pass(0, 2, 4, 0, 1, 3, 1, "R4 ignored start");
    run_pass(2, 2, 8, 0, 1, 3, 1, "R4 ignored start bfly");

    repeat (20) @(negedge clk_i);
    check(exp_q.size() == 0, "R2 all addresses delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule